// File: doc/BRIEF.md
# Exhaustive Functional Test Sequencer for a Dual Four-Way Selector

This block runs a complete functional test on one attached dual four-input selector device. A state machine walks through eight steps, one per clock, covering every select value on each of the two selector halves. Each step's stimulus word changes on the rising clock edge. The output of the half under test is sampled on the falling edge into an eight-bit capture word, with one bit for each step.

A pass is judged on the whole sequence, not on single vectors. After the last step, the capture word is compared with an expected word. That word comes from a device-variant code that is latched when the test starts. One pass bit results, and a one-cycle done pulse marks the end of the pass. The sequence can run once per start pulse, or loop without pause. When it loops, the pass bit is rewritten at the end of every pass. A hold input parks the machine at its first step, with both halves disabled.

Top module: `exhaustive_test_seq`

## Requirements
- R1: While reset is low and after its release with no start, stimOut is 12'hC00 (both enable bits high, select and data zero), and doneOut and passOut are 0.
- R2: Stimulus layout: data of half A on bits 3:0, data of half B on bits 7:4, select on bits 9:8, active-low enable of half A on bit 10 and of half B on bit 11.
  - In step k (k = 0..7), half k/4 is enabled and the other half is disabled.
  - The select field equals k mod 4.
  - In the enabled half, the data line named by the select field carries the inverse of bit 0 of k, and its other lines carry bit 0 of k.
  - The disabled half's data lines are 0.
- R3: The response of step k is taken at the falling clock edge inside step k, from respIn[k/4]. Values that respIn holds at other times within the step do not affect the result.
- R4: A start pulse sampled at rising edge E0 presents step 0 after E0. Step 7 ends at edge E8, and doneOut is high for exactly the one cycle after E8.
- R5: passOut is set to 1 after E8 exactly when the capture word equals the expected word for the latched variant code, and to 0 otherwise. Bit k of the capture word is the response of step k. The expected words are: code 0 8'h55, code 1 8'hAA, code 2 8'h00, code 3 8'hFF. passOut changes only when doneOut rises.
- R6: cfgType is latched only when a start is accepted. Changing it during a run does not affect that run's result.
- R7: With loopMode low at the end of a pass, stimOut returns to 12'hC00 after E8. No further done pulse occurs until a new start.
- R8: With loopMode high at the end of a pass, step 0 is presented right after E8, and a done pulse follows every eight cycles. Each pass's result replaces the previous one, so a failing pass clears passOut and a following good pass sets it again.
- R9: While holdIn is high, stimOut goes to 12'hC00 from the next cycle. A running pass is abandoned with no done pulse and passOut unchanged, and start pulses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; stimulus on rising edge, capture on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| startIn | input | 1 | Begins a test run when idle and not held |
| holdIn | input | 1 | Active-high park at the first step |
| loopMode | input | 1 | 0 = single pass, 1 = repeat passes |
| cfgType | input | 2 | Device variant code choosing the expected word |
| respIn | input | 2 | Outputs of the two selector halves |
| stimOut | output | 12 | Stimulus word to the device |
| doneOut | output | 1 | One-cycle pulse at the end of each pass |
| passOut | output | 1 | Result of the most recent completed pass |

## Verification
The bench crosses all four variant codes with five modelled devices: a correct selector, an inverting one, outputs stuck low, outputs stuck high, and one whose upper select bit is dead. The pass bit must separate the matching pair in each case from every mismatch, including the partial select fault, which only alters half the steps. A separate run keeps a wrong response on respIn everywhere except a narrow window around the falling edge, which shows that the capture edge is the falling one. Loop runs alternate good and faulty devices to show that each pass is judged on its own. Hold pulses applied mid-run and together with start show that a run is abandoned and that start is ignored while held.

// File: rtl/exh_seq_pkg.sv
package exh_seq_pkg;

  // Geometry of the tested function: two halves, each a 2^SEL_W-way selector
  localparam int SEL_W    = 2;
  localparam int LANES    = 1 << SEL_W;
  localparam int HALVES   = 2;
  localparam int HALF_W   = $clog2(HALVES);
  localparam int STEPS    = HALVES * LANES;
  localparam int STEP_W   = $clog2(STEPS);
  localparam int TYPE_W   = 2;
  localparam int DATA_LSB = 0;
  localparam int SEL_LSB  = DATA_LSB + HALVES * LANES;
  localparam int EN_LSB   = SEL_LSB + SEL_W;
  localparam int STIM_W   = EN_LSB + HALVES;

  typedef enum logic {ST_IDLE, ST_RUN} seqState_t;

  // Strobes handed from control to datapath
  typedef struct packed {
    logic              running;
    logic [STEP_W-1:0] stepIdx;
    logic              cfgLoad;
    logic              finish;
  } seqStrobes_t;

  // Stimulus word for a step; all halves disabled when not running
  function automatic logic [STIM_W-1:0] stimFor(input logic run,
                                                input logic [STEP_W-1:0] st);
    logic [STIM_W-1:0] v;
    int half;
    int lane;
    v = '0;
    v[EN_LSB +: HALVES] = '1;
    if (run) begin
      half = int'(st) / LANES;
      lane = int'(st) % LANES;
      v[SEL_LSB +: SEL_W] = SEL_W'(lane);
      v[EN_LSB + half] = 1'b0;
      for (int l = 0; l < LANES; l++) begin
        v[DATA_LSB + half * LANES + l] = (l == lane) ? ~st[0] : st[0];
      end
    end
    return v;
  endfunction

  // Expected capture word per device variant code
  function automatic logic [STEPS-1:0] expectedWord(input logic [TYPE_W-1:0] t);
    logic [STEPS-1:0] w;
    logic b;
    for (int k = 0; k < STEPS; k++) begin
      b = ((k % 2) == 0);
      case (t)
        2'd0:    w[k] = b;
        2'd1:    w[k] = ~b;
        2'd2:    w[k] = 1'b0;
        default: w[k] = 1'b1;
      endcase
    end
    return w;
  endfunction

endpackage

// File: rtl/exh_seq_ctrl.sv
module exh_seq_ctrl
  import exh_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        startIn,
  input  logic        holdIn,
  input  logic        loopMode,
  output seqStrobes_t strobes
);

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);

  seqState_t         state;
  logic [STEP_W-1:0] stepIdx;
  logic              atLast;

  assign atLast = (stepIdx == LAST_STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      stepIdx <= '0;
    end else if (holdIn) begin
      state   <= ST_IDLE;
      stepIdx <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          stepIdx <= '0;
          if (startIn) state <= ST_RUN;
        end
        default: begin
          if (atLast) begin
            stepIdx <= '0;
            if (!loopMode) state <= ST_IDLE;
          end else begin
            stepIdx <= stepIdx + 1'b1;
          end
        end
      endcase
    end
  end

  always_comb begin
    strobes.running = (state == ST_RUN);
    strobes.stepIdx = stepIdx;
    strobes.cfgLoad = (state == ST_IDLE) && startIn && !holdIn;
    strobes.finish  = (state == ST_RUN) && atLast && !holdIn;
  end

endmodule

// File: rtl/exh_seq_datapath.sv
module exh_seq_datapath
  import exh_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  seqStrobes_t       strobes,
  input  logic [TYPE_W-1:0] cfgType,
  input  logic [HALVES-1:0] respIn,
  output logic [STIM_W-1:0] stimOut,
  output logic              doneOut,
  output logic              passOut
);

  logic [STEPS-1:0]  capReg;
  logic [TYPE_W-1:0] cfgReg;
  logic [HALF_W-1:0] halfIdx;
  logic              capBit;

  assign stimOut = stimFor(strobes.running, strobes.stepIdx);
  assign halfIdx = HALF_W'(strobes.stepIdx >> SEL_W);
  assign capBit  = respIn[halfIdx];

  // Falling-edge capture; step 0 starts a fresh word
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      capReg <= '0;
    end else if (strobes.running) begin
      if (strobes.stepIdx == '0) capReg <= STEPS'(capBit);
      else                       capReg[strobes.stepIdx] <= capBit;
    end
  end

  // Rising-edge result and configuration
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfgReg  <= '0;
      doneOut <= 1'b0;
      passOut <= 1'b0;
    end else begin
      if (strobes.cfgLoad) cfgReg <= cfgType;
      doneOut <= strobes.finish;
      if (strobes.finish) passOut <= (capReg == expectedWord(cfgReg));
    end
  end

endmodule

// File: rtl/exhaustive_test_seq.sv
module exhaustive_test_seq
  import exh_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              startIn,
  input  logic              holdIn,
  input  logic              loopMode,
  input  logic [TYPE_W-1:0] cfgType,
  input  logic [HALVES-1:0] respIn,
  output logic [STIM_W-1:0] stimOut,
  output logic              doneOut,
  output logic              passOut
);

  seqStrobes_t strobes;

  exh_seq_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .startIn  (startIn),
    .holdIn   (holdIn),
    .loopMode (loopMode),
    .strobes  (strobes)
  );

  exh_seq_datapath u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobes (strobes),
    .cfgType (cfgType),
    .respIn  (respIn),
    .stimOut (stimOut),
    .doneOut (doneOut),
    .passOut (passOut)
  );

endmodule

// File: rtl/exh_seq_checker.sv
module exh_seq_checker
  import exh_seq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              holdIn,
  input logic              loopMode,
  input logic [STIM_W-1:0] stimOut,
  input logic              doneOut,
  input logic              passOut
);

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    doneOut |=> !doneOut);

  // R9
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    holdIn |=> (stimOut[EN_LSB +: HALVES] == '1));

  // R2
  one_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~stimOut[EN_LSB +: HALVES]) <= 1);

  // R5
  pass_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !doneOut |-> $stable(passOut));

  // R8
  loop_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (doneOut && $past(loopMode)) |->
      (!stimOut[EN_LSB] && stimOut[SEL_LSB +: SEL_W] == '0));

  // R7
  oneshot_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (doneOut && !$past(loopMode)) |-> (stimOut[EN_LSB +: HALVES] == '1));

endmodule

bind exhaustive_test_seq exh_seq_checker u_exh_seq_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .holdIn   (holdIn),
  .loopMode (loopMode),
  .stimOut  (stimOut),
  .doneOut  (doneOut),
  .passOut  (passOut)
);

// File: tb/exhaustive_test_seq_bench.sv
module exhaustive_test_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] IDLE_STIM = 12'hC00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        startIn = 1'b0;
  logic        holdIn = 1'b0;
  logic        loopMode = 1'b0;
  logic [1:0]  cfgType = 2'd0;
  logic [1:0]  respIn;
  logic [11:0] stimOut;
  logic        doneOut;
  logic        passOut;

  int   devKind = 0;
  logic glitch = 1'b0;
  logic corrupt = 1'b1;
  int   checks = 0;
  int   errors = 0;

  exhaustive_test_seq u_exhaustive_test_seq (
    .clk(clk), .rst_n(rst_n), .startIn(startIn), .holdIn(holdIn),
    .loopMode(loopMode), .cfgType(cfgType), .respIn(respIn),
    .stimOut(stimOut), .doneOut(doneOut), .passOut(passOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Corruption window: wrong everywhere except around the falling edge
  initial forever begin
    @(posedge clk);
    #1 corrupt = 1'b1;
    #3 corrupt = 1'b0;
    #2 corrupt = 1'b1;
  end

  // Device models: 0 good, 1 inverting, 2 stuck low, 3 stuck high, 4 dead upper select bit
  function automatic logic [1:0] devModel(input logic [11:0] s, input int kind);
    logic [1:0] o;
    int sel;
    for (int h = 0; h < 2; h++) begin
      sel = int'(s[9:8]);
      if (kind == 4) sel = sel % 2;
      case (kind)
        1:       o[h] = s[10+h] ? 1'b0 : ~s[h*4 + sel];
        2:       o[h] = 1'b0;
        3:       o[h] = 1'b1;
        default: o[h] = s[10+h] ? 1'b0 : s[h*4 + sel];
      endcase
    end
    return o;
  endfunction

  assign respIn = devModel(stimOut, devKind) ^ ((glitch && corrupt) ? 2'b11 : 2'b00);

  function automatic logic [11:0] expStim(input int k);
    logic [11:0] v;
    int h;
    int lane;
    logic b0;
    v = '0;
    h = k / 4;
    lane = k % 4;
    b0 = (k % 2) == 1;
    v[11:10] = 2'b11;
    v[10+h] = 1'b0;
    v[9:8] = 2'(lane);
    for (int l = 0; l < 4; l++) v[h*4 + l] = (l == lane) ? ~b0 : b0;
    return v;
  endfunction

  function automatic logic [7:0] typeWord(input int t);
    case (t)
      0: return 8'h55;
      1: return 8'hAA;
      2: return 8'h00;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] kindWord(input int kind);
    logic [7:0] w;
    logic sv;
    for (int k = 0; k < 8; k++) begin
      sv = (k % 2) == 0;
      case (kind)
        1: w[k] = ~sv;
        2: w[k] = 1'b0;
        3: w[k] = 1'b1;
        4: w[k] = ((k % 4) >= 2) ? ~sv : sv;
        default: w[k] = sv;
      endcase
    end
    return w;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic runOnce(input int t, input int kind, input bit seeStim, input bit flipCfg);
    cfgType = 2'(t);
    devKind = kind;
    startIn = 1'b1;
    @(posedge clk); #1;
    startIn = 1'b0;
    if (flipCfg) cfgType = ~2'(t);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (seeStim) chk("R2 step stimulus", 32'(stimOut), 32'(expStim(k)));
      if (k == 3) chk("R4 done low mid-run", 32'(doneOut), 0);
      @(posedge clk); #1;
    end
    chk("R4 done after last step", 32'(doneOut), 1);
    chk("R5 pass verdict", 32'(passOut), 32'(kindWord(kind) == typeWord(t)));
    @(posedge clk); #1;
    chk("R4 done one cycle", 32'(doneOut), 0);
    chk("R7 idle after one-shot", 32'(stimOut), 32'(IDLE_STIM));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic holdPass;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset stim", 32'(stimOut), 32'(IDLE_STIM));
    chk("R1 reset done", 32'(doneOut), 0);
    chk("R1 reset pass", 32'(passOut), 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 idle after release", 32'(stimOut), 32'(IDLE_STIM));

    // R2 R5: every variant against every device model
    for (int t = 0; t < 4; t++)
      for (int kind = 0; kind < 5; kind++)
        runOnce(t, kind, (t == 0 && kind == 0), 1'b0);

    // R6: variant change during run has no effect
    runOnce(0, 0, 1'b0, 1'b1);
    runOnce(1, 1, 1'b0, 1'b1);

    // R7: no spontaneous activity after a single pass
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #1;
      chk("R7 no extra done", 32'(doneOut), 0);
      chk("R7 stays idle", 32'(stimOut), 32'(IDLE_STIM));
    end

    // R3: response valid only around the falling edge
    glitch = 1'b1;
    runOnce(0, 0, 1'b0, 1'b0);
    runOnce(1, 1, 1'b0, 1'b0);
    glitch = 1'b0;

    // R8: looping with a changing device
    begin
      int kinds[4] = '{0, 4, 0, 1};
      loopMode = 1'b1;
      cfgType = 2'd0;
      devKind = kinds[0];
      startIn = 1'b1;
      @(posedge clk); #1;
      startIn = 1'b0;
      for (int p = 0; p < 4; p++) begin
        if (p == 3) loopMode = 1'b0;
        repeat (8) @(posedge clk);
        #1;
        chk("R8 done each pass", 32'(doneOut), 1);
        chk("R8 pass per pass", 32'(passOut), 32'(kindWord(kinds[p]) == typeWord(0)));
        if (p < 3) begin
          chk("R8 restart at step 0", 32'(stimOut), 32'(expStim(0)));
          devKind = kinds[p+1];
        end else begin
          chk("R7 loop stopped", 32'(stimOut), 32'(IDLE_STIM));
        end
      end
    end

    // R9: hold abandons a run and blocks start
    runOnce(0, 4, 1'b0, 1'b0);
    holdPass = passOut;
    cfgType = 2'd0;
    devKind = 0;
    startIn = 1'b1;
    @(posedge clk); #1;
    startIn = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    holdIn = 1'b1;
    @(posedge clk); #1;
    chk("R9 idle under hold", 32'(stimOut), 32'(IDLE_STIM));
    begin
      int doneSeen = 0;
      for (int i = 0; i < 10; i++) begin
        if (i == 4) startIn = 1'b1;
        @(posedge clk); #1;
        if (doneOut) doneSeen++;
      end
      chk("R9 no done while held", 32'(doneSeen), 0);
    end
    chk("R9 start ignored", 32'(stimOut), 32'(IDLE_STIM));
    chk("R9 pass unchanged", 32'(passOut), 32'(holdPass));
    holdIn = 1'b0;
    startIn = 1'b0;
    @(posedge clk); #1;
    chk("R9 no late start", 32'(stimOut), 32'(IDLE_STIM));
    runOnce(2, 2, 1'b0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule